// File: doc/BRIEF.md
# Soft-Start and Auto-Mute Sequencer

This block sequences the output stage of a stereo audio converter through power-up and power-down, and raises a mute flag for an external mute circuit. It does not touch the analog side. It produces digital state and a level code, and the analog ramp generator and the discharge current sink act on them.

While the active-low reset is held, the block is in discharge mode. After reset is released, the outputs are clamped to ground for a programmable number of sample periods. The level code then climbs one step per sample, from zero to a terminal value that stands for the quiescent level. Audio output is enabled only once the code reaches that terminal value.

The mute flag is high when any of these holds:
- the block has not yet reached audio output;
- the mode detector reports a bad master-clock ratio;
- both channels have carried silence for a long run of samples. Silence means every word is all zeros or all ones.

One sample that breaks the silent run clears the flag again.

Top module: `softstart_mute_seq`

## Requirements
- R1: While `rst_n` is low, `discharge_o`=1, `audio_en_o`=0, `clamp_en_o`=0, `ramp_code_o`=0 and `mute_o`=1. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R2: `rst_n` is released through a two-stage synchronizer. On the third rising clock edge after release, the block enters the clamp phase, with `clamp_en_o`=1 and `ramp_code_o`=0. `clamp_en_o` stays high for exactly CLAMP_SAMPLES sample strobes.
- R3: In the ramp phase, `ramp_code_o` rises by exactly one on each sample strobe. It goes from 0 to RAMP_MAX, so the ramp phase lasts RAMP_MAX strobes. `clamp_en_o` is 0 during the ramp phase.
- R4: `audio_en_o` rises on the strobe that brings `ramp_code_o` to RAMP_MAX. From then on, both `audio_en_o` and `ramp_code_o` hold their values until `rst_n` is asserted.
- R5: `mute_o` is 1 in every phase other than audio output.
- R6: `mute_o` is 1 in any cycle in which `ratio_err` is 1. This is a combinational path with no clock delay.
- R7: `ratio_err` has no effect on the clamp, ramp or audio-enable sequence. A ratio error in the middle of a ramp neither restarts the ramp nor stalls it.
- R8: A sample is idle when each channel word is all zeros or all ones. `mute_o` goes to 1 after the IDLE_SAMPLES-th consecutive idle strobe.
- R9: The idle run counter saturates, so further idle strobes keep `mute_o` at 1. A single non-idle strobe clears the counter, and `mute_o` is 0 after that strobe when no other mute cause is present.
- R10: Only cycles with `sample_stb`=1 are counted. Sample words presented without a strobe do not change the idle count, `mute_o` or `ramp_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; low selects discharge mode |
| sample_stb | input | 1 | One-cycle pulse per stereo frame |
| ratio_err | input | 1 | Master-clock ratio fault from the mode detector |
| left_smp | input | DW | Left channel word, valid with `sample_stb` |
| right_smp | input | DW | Right channel word, valid with `sample_stb` |
| clamp_en_o | output | 1 | Holds the outputs at ground |
| ramp_code_o | output | RAMP_W | Output level code, 0 = ground, RAMP_MAX = quiescent |
| audio_en_o | output | 1 | Audio path connected to the outputs |
| discharge_o | output | 1 | Discharge sink selected instead of the drivers |
| mute_o | output | 1 | External mute control |

## Verification
The bench runs the start-up with small parameter values. It checks the clamp state and the level code after every single strobe, so an off-by-one in either phase length shows up as a wrong code or a late audio enable. A second start-up, after reset is asserted in mid-operation, injects a ratio error during the ramp. This separates a mute-only reaction from one that restarts or stalls the ramp.

The idle detector is swept over every pairing of six word patterns on the two channels. The patterns are all zeros, all ones, and near misses of both. For each pair, the bench sends a run of exactly IDLE_SAMPLES strobes, so a wrong classification or a run length that is short by one gives the wrong flag. Saturation, clearing by a single loud sample, and words held without a strobe are each checked on their own.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SEQ_DISCH = 2'd0,
    SEQ_CLAMP = 2'd1,
    SEQ_RAMP  = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ssm_rst_sync.sv
module ssm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ssm_startup.sv
module ssm_startup
  import ssm_pkg::*;
#(
  parameter int CLAMP_SAMPLES = 1000,
  parameter int RAMP_W        = 14,
  parameter int RAMP_MAX      = 10000
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              sample_stb,
  output seq_state_e        state_o,
  output logic [RAMP_W-1:0] ramp_o
);

  localparam int CW = $clog2(CLAMP_SAMPLES + 1);
  localparam logic [CW-1:0]     DLY_LAST  = CW'(CLAMP_SAMPLES - 1);
  localparam logic [RAMP_W-1:0] RAMP_LAST = RAMP_W'(RAMP_MAX - 1);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     dly_q, dly_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    ramp_d  = ramp_q;
    case (state_q)
      SEQ_DISCH: begin
        state_d = SEQ_CLAMP;
        dly_d   = '0;
        ramp_d  = '0;
      end
      SEQ_CLAMP: begin
        if (sample_stb) begin
          if (dly_q == DLY_LAST) begin
            state_d = SEQ_RAMP;
            dly_d   = '0;
          end else begin
            dly_d = dly_q + CW'(1);
          end
        end
      end
      SEQ_RAMP: begin
        if (sample_stb) begin
          ramp_d = ramp_q + RAMP_W'(1);
          if (ramp_q == RAMP_LAST) begin
            state_d = SEQ_RUN;
          end
        end
      end
      default: begin
        state_d = SEQ_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_DISCH;
      dly_q   <= '0;
      ramp_q  <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      ramp_q  <= ramp_d;
    end
  end

  assign state_o = state_q;
  assign ramp_o  = ramp_q;

endmodule

// File: rtl/ssm_idle_det.sv
module ssm_idle_det #(
  parameter int DW           = 24,
  parameter int IDLE_SAMPLES = 8192
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          sample_stb,
  input  logic [DW-1:0] left_smp,
  input  logic [DW-1:0] right_smp,
  output logic          idle_o
);

  localparam int IW = $clog2(IDLE_SAMPLES + 1);
  localparam logic [IW-1:0] RUN_FULL = IW'(IDLE_SAMPLES);

  logic          left_static;
  logic          right_static;
  logic          frame_idle;
  logic [IW-1:0] run_q, run_d;

  always_comb begin
    left_static  = (&left_smp)  | ~(|left_smp);
    right_static = (&right_smp) | ~(|right_smp);
    frame_idle   = left_static & right_static;
    run_d        = run_q;
    if (sample_stb) begin
      if (!frame_idle) begin
        run_d = '0;
      end else if (run_q != RUN_FULL) begin
        run_d = run_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  assign idle_o = (run_q == RUN_FULL);

endmodule

// File: rtl/softstart_mute_seq.sv
module softstart_mute_seq
  import ssm_pkg::*;
#(
  parameter int DW            = 24,
  parameter int CLAMP_SAMPLES = 1000,
  parameter int RAMP_W        = 14,
  parameter int RAMP_MAX      = 10000,
  parameter int IDLE_SAMPLES  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic              ratio_err,
  input  logic [DW-1:0]     left_smp,
  input  logic [DW-1:0]     right_smp,
  output logic              clamp_en_o,
  output logic [RAMP_W-1:0] ramp_code_o,
  output logic              audio_en_o,
  output logic              discharge_o,
  output logic              mute_o
);

  logic       rst_sync_n;
  seq_state_e seq_state;
  logic       idle_run;

  ssm_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ssm_startup #(
    .CLAMP_SAMPLES (CLAMP_SAMPLES),
    .RAMP_W        (RAMP_W),
    .RAMP_MAX      (RAMP_MAX)
  ) u_startup (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .sample_stb (sample_stb),
    .state_o    (seq_state),
    .ramp_o     (ramp_code_o)
  );

  ssm_idle_det #(
    .DW           (DW),
    .IDLE_SAMPLES (IDLE_SAMPLES)
  ) u_idle (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .sample_stb (sample_stb),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .idle_o     (idle_run)
  );

  always_comb begin
    clamp_en_o  = (seq_state == SEQ_CLAMP);
    audio_en_o  = (seq_state == SEQ_RUN);
    discharge_o = (seq_state == SEQ_DISCH);
    mute_o      = (seq_state != SEQ_RUN) | ratio_err | idle_run;
  end

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int RAMP_W   = 14,
  parameter int RAMP_MAX = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic              ratio_err,
  input logic              clamp_en_o,
  input logic [RAMP_W-1:0] ramp_code_o,
  input logic              audio_en_o,
  input logic              discharge_o,
  input logic              mute_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_DISCHARGE: assert (discharge_o && !audio_en_o && mute_o); // R1
    end
  end

  AST_CLAMP_AT_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en_o |-> (ramp_code_o == '0)); // R2

  AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code_o != $past(ramp_code_o)) |->
      (ramp_code_o == $past(ramp_code_o) + RAMP_W'(1))); // R3

  AST_AUDIO_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en_o |-> (ramp_code_o == RAMP_W'(RAMP_MAX))); // R4

  AST_AUDIO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en_o |=> audio_en_o); // R4

  AST_MUTE_ON_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> mute_o); // R6

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(ramp_code_o)); // R10

endmodule

bind softstart_mute_seq ssm_checker #(
  .RAMP_W   (RAMP_W),
  .RAMP_MAX (RAMP_MAX)
) u_ssm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .ratio_err   (ratio_err),
  .clamp_en_o  (clamp_en_o),
  .ramp_code_o (ramp_code_o),
  .audio_en_o  (audio_en_o),
  .discharge_o (discharge_o),
  .mute_o      (mute_o)
);

// File: tb/softstart_mute_seq_bench.sv
module softstart_mute_seq_bench;

  localparam int DW    = 8;
  localparam int CLAMP = 5;
  localparam int RW    = 6;
  localparam int RMAX  = 12;
  localparam int IDLE  = 8;

  logic          clk;
  logic          rst_n;
  logic          sample_stb;
  logic          ratio_err;
  logic [DW-1:0] left_smp;
  logic [DW-1:0] right_smp;
  logic          clamp_en_o;
  logic [RW-1:0] ramp_code_o;
  logic          audio_en_o;
  logic          discharge_o;
  logic          mute_o;

  int n_run;
  int n_fail;

  softstart_mute_seq #(
    .DW            (DW),
    .CLAMP_SAMPLES (CLAMP),
    .RAMP_W        (RW),
    .RAMP_MAX      (RMAX),
    .IDLE_SAMPLES  (IDLE)
  ) u_softstart_mute_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_stb  (sample_stb),
    .ratio_err   (ratio_err),
    .left_smp    (left_smp),
    .right_smp   (right_smp),
    .clamp_en_o  (clamp_en_o),
    .ramp_code_o (ramp_code_o),
    .audio_en_o  (audio_en_o),
    .discharge_o (discharge_o),
    .mute_o      (mute_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [DW-1:0] l, input logic [DW-1:0] r);
    @(negedge clk);
    sample_stb = 1'b1;
    left_smp   = l;
    right_smp  = r;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 discharge", int'(discharge_o), 1);
    chk("R1 audio_en", int'(audio_en_o), 0);
    chk("R1 clamp", int'(clamp_en_o), 0);
    chk("R1 code", int'(ramp_code_o), 0);
    chk("R1 mute", int'(mute_o), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 still discharging in sync", int'(discharge_o), 1);
    @(negedge clk);
    chk("R2 clamp entry", int'(clamp_en_o), 1);
    chk("R2 clamp code", int'(ramp_code_o), 0);
  endtask

  task automatic startup(input bit inject_ratio);
    for (int i = 0; i < CLAMP; i++) begin
      strobe(8'h11, 8'h22);
      chk("R2 clamp length", int'(clamp_en_o), (i < CLAMP - 1) ? 1 : 0);
      chk("R2 code at ground", int'(ramp_code_o), 0);
    end
    for (int j = 0; j < RMAX; j++) begin
      if (inject_ratio && j == 4) begin
        @(negedge clk);
        ratio_err = 1'b1;
        #1;
        chk("R6 mute on ratio", int'(mute_o), 1);
      end
      strobe(8'h33, 8'h44);
      if (inject_ratio && j == 4) begin
        ratio_err = 1'b0;
      end
      chk(inject_ratio ? "R7 ramp unaffected" : "R3 ramp step",
          int'(ramp_code_o), j + 1);
      chk("R4 audio at top", int'(audio_en_o), (j == RMAX - 1) ? 1 : 0);
      chk("R3 clamp off", int'(clamp_en_o), 0);
      if (j < RMAX - 1) chk("R5 mute while ramping", int'(mute_o), 1);
    end
    strobe(8'h55, 8'h66);
    chk("R5 mute released in run", int'(mute_o), 0);
    chk("R4 code held", int'(ramp_code_o), RMAX);
    chk("R4 audio held", int'(audio_en_o), 1);
  endtask

  function automatic bit is_static(input logic [DW-1:0] w);
    return (w == '0) || (w == '1);
  endfunction

  initial begin
    logic [DW-1:0] pats [6];
    n_run      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    sample_stb = 1'b0;
    ratio_err  = 1'b0;
    left_smp   = '0;
    right_smp  = '0;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h01;
    pats[3] = 8'h80; pats[4] = 8'h7F; pats[5] = 8'hFE;

    repeat (2) @(negedge clk);
    do_reset();
    startup(1'b0);

    // R6 in run: mute follows ratio_err in the same cycle
    @(negedge clk);
    ratio_err = 1'b1;
    #1;
    chk("R6 mute on ratio in run", int'(mute_o), 1);
    @(negedge clk);
    ratio_err = 1'b0;
    #1;
    chk("R6 mute follows ratio low", int'(mute_o), 0);

    // R8 sweep over channel word pairs
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        strobe(8'h5A, 8'h5A);
        for (int k = 0; k < IDLE - 1; k++) strobe(pats[a], pats[b]);
        chk("R8 below run length", int'(mute_o), 0);
        strobe(pats[a], pats[b]);
        chk("R8 idle classification", int'(mute_o),
            (is_static(pats[a]) && is_static(pats[b])) ? 1 : 0);
      end
    end

    // R9 saturation and single-sample clear
    strobe(8'h5A, 8'h5A);
    for (int k = 0; k < IDLE + 5; k++) strobe(8'hFF, 8'h00);
    chk("R9 saturated stays muted", int'(mute_o), 1);
    strobe(8'h00, 8'h02);
    chk("R9 single loud sample clears", int'(mute_o), 0);
    for (int k = 0; k < IDLE - 1; k++) strobe(8'h00, 8'h00);
    chk("R9 count restarted", int'(mute_o), 0);

    // R10 words without strobe are ignored
    @(negedge clk);
    left_smp  = 8'h00;
    right_smp = 8'h00;
    repeat (20) @(negedge clk);
    chk("R10 no strobe no count", int'(mute_o), 0);
    chk("R10 code stable", int'(ramp_code_o), RMAX);
    strobe(8'h00, 8'h00);
    chk("R10 strobe completes run", int'(mute_o), 1);

    // reset mid-operation, then restart with a ratio fault in the ramp
    do_reset();
    startup(1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule